// File: doc/BRIEF.md
# Clock-Independent Level Event Capture Bank

This block watches eight power-related input lines and records a level event on any of them in a per-channel flag. The flag is set directly by the enabled, polarity-adjusted input through an asynchronous set, so an event is captured even while the bus clock is stopped. Once the clock runs again, each flag passes through a two-flop synchronizer into the bus clock domain, where it appears as raw status. It is then qualified by the channel enable to form masked status, and the OR of the masked bits drives a single interrupt line.

Software reaches the bank through a simple 32-bit register port with separate write and read strobes. Each register holds one bit per channel in bits [7:0]. A channel is armed by setting its enable bit and choosing its active level. The interrupt service reads masked status to find pending channels and writes ones to the clear register to release them. A clear written while the input is still active does not hold: the flag sets again at once. A mode word is kept for software but has no effect on capture.

Top module: `pwr_event_latch`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Enable (0x00), polarity (0x10) and mode (0x14) are read-write in bits [7:0], with bit i belonging to channel i. Bits [31:8] of any read are 0.
- R3: A polarity bit of 0 makes its channel active while the input is high. A polarity bit of 1 makes it active while the input is low. Capture is by level only.
- R4: An enabled channel whose input becomes active sets its flag without a clock. Raw status (0x04) shows the flag from the second rising clock edge after it sets, including an event that began and ended while the clock was stopped.
- R5: A channel whose enable bit is 0 does not set its flag when its input is active.
- R6: Writing 1 to bit i of the clear register (0x0C) releases flag i at that write's clock edge. Raw status still shows 1 one edge later and shows 0 from the second edge after the write. Writing 0 to a bit leaves that flag unchanged, and the clear register reads 0.
- R7: If a channel's input is still active when its clear is written, the flag stays set and raw status remains 1.
- R8: Masked status (0x08) is raw status ANDed with the enable bits, and `irq` is high exactly when masked status is non-zero.
- R9: The value held in mode has no effect on capture timing or status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; may be stopped |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| rd_en | input | 1 | Register read strobe; `rdata` is valid in the same cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when `rd_en` is low |
| evt_in | input | 8 | Raw event inputs, one per channel |
| irq | output | 1 | Interrupt request, OR of masked status |

## Verification
The hardest situation to reach is an event that arrives and disappears while the bus clock is frozen. A test of it has to show that the flag held the event on its own and that the synchronizer delivers it once edges resume. The bench gates its own clock generator low, pulses one input, and releases it before restarting the clock. It then checks raw status exactly two edges after the restart. A second awkward case is a clear that races an input still held active. The bench holds the input, writes the clear, and confirms that raw status never drops.

// File: rtl/pel_pkg.sv
package pel_pkg;
    localparam int NUM_CH = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_POLAR  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h14;
endpackage

// File: rtl/pel_flag_cell.sv
// One event flag: set asynchronously by its arm input, released by a
// synchronous clear pulse. Set wins over clear.
module pel_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or posedge arm or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (arm)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/pel_sync2.sv
// Two-flop synchronizer, one per bit.
module pel_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pel_regs.sv
// Register file: control storage, clear pulse generation and read mux.
module pel_regs
    import pel_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N-1:0]      raw_sts,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      clr_pulse,
    output logic [N-1:0]      masked_sts
);
    localparam int PAD = DATA_W - N;

    logic [N-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_ENABLE) en_q   <= wdata[N-1:0];
            if (addr == OFS_POLAR)  pol_q  <= wdata[N-1:0];
            if (addr == OFS_MODE)   mode_q <= wdata[N-1:0];
        end
    end

    always_comb begin
        clr_pulse = '0;
        if (wr_en && (addr == OFS_CLEAR))
            clr_pulse = wdata[N-1:0];
    end

    assign masked_sts = raw_sts & en_q;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_ENABLE: rdata = {{PAD{1'b0}}, en_q};
                OFS_RAW:    rdata = {{PAD{1'b0}}, raw_sts};
                OFS_MASKED: rdata = {{PAD{1'b0}}, masked_sts};
                OFS_POLAR:  rdata = {{PAD{1'b0}}, pol_q};
                OFS_MODE:   rdata = {{PAD{1'b0}}, mode_q};
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pwr_event_latch.sv
module pwr_event_latch
    import pel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_CH-1:0] evt_in,
    output logic              irq
);
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] pol_q;
    logic [NUM_CH-1:0] clr_vec;
    logic [NUM_CH-1:0] arm_vec;
    logic [NUM_CH-1:0] flag_q;
    logic [NUM_CH-1:0] raw_sync;
    logic [NUM_CH-1:0] masked;

    // polarity 0: high is active, polarity 1: low is active
    assign arm_vec = en_q & (evt_in ^ pol_q);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cell
            pel_flag_cell u_cell (
                .clk  (clk),
                .rst_n(rst_n),
                .arm  (arm_vec[ch]),
                .clr  (clr_vec[ch]),
                .flag (flag_q[ch])
            );
        end
    endgenerate

    pel_sync2 #(.W(NUM_CH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (flag_q),
        .q    (raw_sync)
    );

    pel_regs #(.N(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .raw_sts   (raw_sync),
        .en_q      (en_q),
        .pol_q     (pol_q),
        .clr_pulse (clr_vec),
        .masked_sts(masked)
    );

    assign irq = |masked;
endmodule

// File: rtl/pel_checker.sv
module pel_checker
    import pel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] flag,
    input logic [NUM_CH-1:0] raw,
    input logic [NUM_CH-1:0] clr,
    input logic [NUM_CH-1:0] enable,
    input logic              irq,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata
);
    AST_RAW_RISE_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~$past(raw)) & ~$past(flag, 2)) == '0); // R4

    AST_RAW_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((~raw & $past(raw)) & ~$past(clr, 3)) == '0); // R6

    AST_IRQ_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq); // R8

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_CLEAR) |-> (rdata == '0)); // R6

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:NUM_CH] == '0); // R2
endmodule

bind pwr_event_latch pel_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .flag  (flag_q),
    .raw   (raw_sync),
    .clr   (clr_vec),
    .enable(en_q),
    .irq   (irq),
    .rd_en (rd_en),
    .addr  (addr),
    .rdata (rdata)
);

// File: tb/pwr_event_latch_tb.sv
module pwr_event_latch_tb;
    import pel_pkg::*;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              clk_run = 1'b1;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [NUM_CH-1:0] evt_in = '0;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pwr_event_latch u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .evt_in(evt_in),
        .irq   (irq)
    );

    always begin
        #(CLK_P/2);
        if (clk_run) clk = ~clk;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        rd_check("R1 enable",  OFS_ENABLE, 32'h0);
        rd_check("R1 raw",     OFS_RAW,    32'h0);
        rd_check("R1 masked",  OFS_MASKED, 32'h0);
        rd_check("R1 clear",   OFS_CLEAR,  32'h0);
        rd_check("R1 polar",   OFS_POLAR,  32'h0);
        rd_check("R1 mode",    OFS_MODE,   32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_regs();
        wr(OFS_POLAR, 32'hFFFF_FFA5);
        wr(OFS_MODE,  32'hFFFF_FFFF);
        rd_check("R2 polar readback", OFS_POLAR, 32'h0000_00A5);
        rd_check("R2 mode readback",  OFS_MODE,  32'h0000_00FF);
        wr(OFS_POLAR, 32'h0);
        rd_check("R2 polar rewrite", OFS_POLAR, 32'h0);
    endtask

    // capture with mode = 0xFF, exact synchronizer timing
    task automatic t_capture();
        wr(OFS_ENABLE, 32'h01);
        rd_check("R2 enable readback", OFS_ENABLE, 32'h01);
        evt_in[0] = 1'b1;
        cycles(1);
        rd_check("R4 raw after one edge", OFS_RAW, 32'h00);
        cycles(1);
        rd_check("R4 R9 raw after two edges", OFS_RAW, 32'h01);
        rd_check("R8 masked", OFS_MASKED, 32'h01);
        check("R8 irq high", {31'h0, irq}, 32'h1);
        evt_in[0] = 1'b0;
        cycles(2);
        rd_check("R4 flag held after input drops", OFS_RAW, 32'h01);
        wr(OFS_CLEAR, 32'hFFFF_FFFE);
        cycles(2);
        rd_check("R6 zero bit leaves flag", OFS_RAW, 32'h01);
        wr(OFS_CLEAR, 32'h01);
        rd_check("R6 raw at write edge", OFS_RAW, 32'h01);
        cycles(1);
        rd_check("R6 raw one edge later", OFS_RAW, 32'h01);
        cycles(1);
        rd_check("R6 raw released", OFS_RAW, 32'h00);
        check("R8 irq low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_stopped_clock();
        wr(OFS_ENABLE, 32'h02);
        @(negedge clk);
        clk_run = 1'b0;
        #(CLK_P*3);
        evt_in[1] = 1'b1;
        #(CLK_P*2);
        evt_in[1] = 1'b0;
        #(CLK_P*3);
        clk_run = 1'b1;
        cycles(1);
        rd_check("R4 stopped clock one edge", OFS_RAW, 32'h00);
        cycles(1);
        rd_check("R4 stopped clock event held", OFS_RAW, 32'h02);
        wr(OFS_CLEAR, 32'h02);
        cycles(2);
        rd_check("R6 stopped clock clear", OFS_RAW, 32'h00);
    endtask

    task automatic t_polarity();
        evt_in[2] = 1'b1;
        wr(OFS_POLAR, 32'h04);
        wr(OFS_ENABLE, 32'h04);
        cycles(3);
        rd_check("R3 high input with active-low", OFS_RAW, 32'h00);
        evt_in[2] = 1'b0;
        cycles(3);
        rd_check("R3 low input with active-low", OFS_RAW, 32'h04);
        evt_in[2] = 1'b1;
        wr(OFS_CLEAR, 32'h04);
        cycles(3);
        rd_check("R3 released when inactive", OFS_RAW, 32'h00);
        wr(OFS_ENABLE, 32'h0);
        wr(OFS_POLAR, 32'h0);
        evt_in[2] = 1'b0;
    endtask

    task automatic t_disabled();
        wr(OFS_ENABLE, 32'hF7);
        evt_in[3] = 1'b1;
        cycles(4);
        rd_check("R5 disabled channel", OFS_RAW, 32'h00);
        check("R5 irq stays low", {31'h0, irq}, 32'h0);
        evt_in[3] = 1'b0;
        wr(OFS_ENABLE, 32'h0);
    endtask

    task automatic t_clear_active();
        wr(OFS_ENABLE, 32'h10);
        evt_in[4] = 1'b1;
        cycles(3);
        rd_check("R7 set before clear", OFS_RAW, 32'h10);
        wr(OFS_CLEAR, 32'h10);
        rd_check("R7 edge after clear", OFS_RAW, 32'h10);
        cycles(1);
        rd_check("R7 still set", OFS_RAW, 32'h10);
        cycles(2);
        rd_check("R7 re-set by active input", OFS_RAW, 32'h10);
        evt_in[4] = 1'b0;
        wr(OFS_CLEAR, 32'h10);
        cycles(3);
        rd_check("R7 cleared once inactive", OFS_RAW, 32'h00);
        wr(OFS_ENABLE, 32'h0);
    endtask

    task automatic t_mask();
        wr(OFS_ENABLE, 32'h20);
        evt_in[5] = 1'b1;
        cycles(3);
        evt_in[5] = 1'b0;
        wr(OFS_ENABLE, 32'h00);
        rd_check("R8 raw kept after disable", OFS_RAW, 32'h20);
        rd_check("R8 masked off", OFS_MASKED, 32'h00);
        check("R8 irq off", {31'h0, irq}, 32'h0);
        wr(OFS_ENABLE, 32'h20);
        rd_check("R8 masked back", OFS_MASKED, 32'h20);
        check("R8 irq back", {31'h0, irq}, 32'h1);
        wr(OFS_CLEAR, 32'h20);
        cycles(2);
        wr(OFS_ENABLE, 32'h0);
    endtask

    task automatic t_mode();
        wr(OFS_MODE, 32'h00);
        wr(OFS_ENABLE, 32'h40);
        evt_in[6] = 1'b1;
        cycles(1);
        rd_check("R9 mode 0 one edge", OFS_RAW, 32'h00);
        cycles(1);
        rd_check("R9 mode 0 two edges", OFS_RAW, 32'h40);
        evt_in[6] = 1'b0;
        wr(OFS_CLEAR, 32'h40);
        cycles(2);
        rd_check("R9 mode 0 clear", OFS_RAW, 32'h00);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_P*100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        cycles(3);
        t_reset();
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_regs();
        t_capture();
        t_stopped_clock();
        t_polarity();
        t_disabled();
        t_clear_active();
        t_mask();
        t_mode();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule